// File: doc/BRIEF.md
# I2C Bus Start/Stop Monitor

This block watches the two lines of an I2C bus without ever driving them. It tracks the bus framing conditions and keeps two status bits. The busy bit is set by a Start condition. The released bit is set by a Stop condition. From these two bits it derives a bus-free indication. A node that wants to act as a master checks that indication before it claims the bus.

When its interrupt enable is high, the block emits a single-cycle interrupt pulse when a Stop ends a transfer that a Start had opened. Software learns from it that a busy bus has become free. Both status bits are cleared by reset and for as long as the monitor is disabled. The raw line inputs pass through synchronizers first, so the block can sit on asynchronous pads.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, busy_o = 0, released_o = 0, bus_free_o = 1 and stop_irq_o = 0.
- R2: A falling edge on SDA while SCL is high (Start) sets busy_o to 1 and clears released_o. bus_free_o is then 0.
- R3: A rising edge on SDA while SCL is high (Stop) sets released_o to 1 and clears busy_o. bus_free_o is then 1.
- R4: A change of SDA while SCL is low leaves busy_o, released_o and stop_irq_o unchanged. A change of SCL alone also leaves them unchanged.
- R5: While mon_en_i is 0, busy_o and released_o read 0 from the first clock edge on, and Start and Stop conditions are ignored. When the monitor is enabled again, both bits are still 0 and bus_free_o is 1.
- R6: When irq_en_i is 1, a Stop seen while busy_o is 1 raises stop_irq_o for exactly one clock cycle. The pulse comes in the same cycle that released_o becomes 1.
- R7: No interrupt is raised for a Stop while irq_en_i is 0. No interrupt is raised for a Stop that arrives while busy_o is already 0.
- R8: A repeated Start while busy_o is 1 keeps busy_o at 1 and released_o at 0. A Start after a Stop clears released_o.
- R9: A line change first shows on the outputs at the third rising clock edge after it. The second edge still shows the old values. This is two synchronizer stages plus one status register.
- R10: busy_o and released_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| mon_en_i | input | 1 | Monitor enable; 0 clears and freezes the status bits |
| irq_en_i | input | 1 | Enables the Stop interrupt pulse |
| busy_o | output | 1 | Start seen, no Stop yet |
| released_o | output | 1 | Stop seen as the most recent condition |
| bus_free_o | output | 1 | Bus may be claimed: released, or idle with both bits clear |
| stop_irq_o | output | 1 | One-cycle pulse on a Stop that ends a busy bus |

## Verification
The stimulus sets SDA edges while SCL is high against the same edges while SCL is low. This tells real framing conditions apart from ordinary data bits. Stops are applied in three cases: after a Start, with the interrupt masked, and with no Start before them. Together these separate the rule for setting the status bit from the rule for raising the interrupt. Repeated Starts, a Start that follows a Stop, and conditions sent while disabled test the clear and hold rules of both bits. Each line change is also checked one edge before its expected effect, which pins down the three-edge latency.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

  localparam int unsigned LINE_CNT = 2;
  localparam int unsigned SCL_IDX  = 0;
  localparam int unsigned SDA_IDX  = 1;

  typedef enum logic [1:0] {
    COND_NONE  = 2'd0,
    COND_START = 2'd1,
    COND_STOP  = 2'd2
  } bus_cond_e;

  typedef struct packed {
    logic busy;
    logic released;
  } bus_state_t;

endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST:0], 1'b1};
    chain_d = chain_d[LAST:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = raw_i;
      end else begin : g_rest
        always_comb stage_d[g] = stage_q[g-1];
      end

      // Idle bus level is high on both lines.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '1;
        end else begin
          stage_q[g] <= stage_d[g];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[LAST];

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_watch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_s,
  input  logic      sda_s,
  output bus_cond_e cond_o
);

  logic scl_prev_q, sda_prev_q;
  logic scl_prev_d, sda_prev_d;
  logic scl_held;
  logic sda_fell, sda_rose;

  always_comb begin
    scl_prev_d = scl_s;
    sda_prev_d = sda_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_prev_d;
      sda_prev_q <= sda_prev_d;
    end
  end

  always_comb begin
    scl_held = scl_prev_q & scl_s;
    sda_fell = sda_prev_q & ~sda_s;
    sda_rose = ~sda_prev_q & sda_s;
    cond_o   = COND_NONE;
    if (scl_held && sda_fell) begin
      cond_o = COND_START;
    end else if (scl_held && sda_rose) begin
      cond_o = COND_STOP;
    end
  end

  // R4: a clock that is low, now or one cycle ago, never frames a condition
  a_r4_no_cond_scl_low : assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_s || !scl_prev_q) |-> (cond_o == COND_NONE));

endmodule

// File: rtl/i2c_bus_status.sv
module i2c_bus_status
  import i2c_watch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mon_en_i,
  input  logic      irq_en_i,
  input  bus_cond_e cond_i,
  output logic      busy_o,
  output logic      released_o,
  output logic      bus_free_o,
  output logic      stop_irq_o
);

  bus_state_t st_q, st_d;
  logic       irq_q, irq_d;

  always_comb begin
    st_d  = st_q;
    irq_d = 1'b0;
    if (!mon_en_i) begin
      st_d = '0;
    end else begin
      unique case (cond_i)
        COND_START: begin
          st_d.busy     = 1'b1;
          st_d.released = 1'b0;
        end
        COND_STOP: begin
          irq_d         = irq_en_i & st_q.busy;
          st_d.busy     = 1'b0;
          st_d.released = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
    end
  end

  assign busy_o     = st_q.busy;
  assign released_o = st_q.released;
  assign bus_free_o = st_q.released | ~(st_q.busy | st_q.released);
  assign stop_irq_o = irq_q;

  // R10
  a_r10_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && released_o));
  // R5
  a_r5_disable_clears : assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en_i |=> (!busy_o && !released_o));
  // R2
  a_r2_start_sets_busy : assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en_i && cond_i == COND_START) |=> (busy_o && !released_o));
  // R3
  a_r3_stop_sets_released : assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en_i && cond_i == COND_STOP) |=> (released_o && !busy_o));
  // R6
  a_r6_irq_with_stop : assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq_o |-> (released_o && $past(busy_o)));
  // R6
  a_r6_irq_single : assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq_o |=> !stop_irq_o);
  // R7
  a_r7_masked_no_irq : assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |=> !stop_irq_o);

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import i2c_watch_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic mon_en_i,
  input  logic irq_en_i,
  output logic busy_o,
  output logic released_o,
  output logic bus_free_o,
  output logic stop_irq_o
);

  logic                rst_core_n;
  logic [LINE_CNT-1:0] raw_lines;
  logic [LINE_CNT-1:0] sync_lines;
  bus_cond_e           cond;

  always_comb begin
    raw_lines          = '1;
    raw_lines[SCL_IDX] = scl_i;
    raw_lines[SDA_IDX] = sda_i;
  end

  i2c_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  i2c_line_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .raw_i  (raw_lines),
    .sync_o (sync_lines)
  );

  i2c_cond_detect u_det (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .scl_s  (sync_lines[SCL_IDX]),
    .sda_s  (sync_lines[SDA_IDX]),
    .cond_o (cond)
  );

  i2c_bus_status u_stat (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .mon_en_i   (mon_en_i),
    .irq_en_i   (irq_en_i),
    .cond_i     (cond),
    .busy_o     (busy_o),
    .released_o (released_o),
    .bus_free_o (bus_free_o),
    .stop_irq_o (stop_irq_o)
  );

endmodule

// File: tb/i2c_bus_watch_test.sv
module i2c_bus_watch_test;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda, en, ie;
  logic busy, rel, free, irq;

  int unsigned cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int unsigned due;
    logic s, p, irq;
    string tag;
  } exp_t;

  exp_t q[$];
  logic cur_s, cur_p;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_bus_watch uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .mon_en_i(en), .irq_en_i(ie),
    .busy_o(busy), .released_o(rel), .bus_free_o(free), .stop_irq_o(irq)
  );

  function automatic void push(int unsigned due, logic s, logic p, logic i, string tag);
    exp_t e;
    e.due = due; e.s = s; e.p = p; e.irq = i; e.tag = tag;
    q.push_back(e);
  endfunction

  // Monitor: compare outputs against queued expectations mid-cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      logic ef;
      e = q.pop_front();
      ef = e.p | (~e.s & ~e.p);
      checks++;
      if (busy !== e.s || rel !== e.p || free !== ef || irq !== e.irq) begin
        errors++;
        $display("FAIL %s: got busy=%b rel=%b free=%b irq=%b, expected busy=%b rel=%b free=%b irq=%b",
                 e.tag, busy, rel, free, irq, e.s, e.p, ef, e.irq);
      end
    end
  end

  // Line step: effect expected at the third edge (R9), old state at the second.
  task automatic line_step(logic n_sda, logic n_scl, logic ns, logic np, logic ni, string tag);
    int unsigned c;
    @(negedge clk);
    sda = n_sda; scl = n_scl;
    c = cyc;
    push(c + 2, cur_s, cur_p, 1'b0, {tag, " R9 before"});
    push(c + 3, ns, np, ni, tag);
    push(c + 4, ns, np, 1'b0, {tag, " R6 pulse end"});
    cur_s = ns; cur_p = np;
    repeat (6) @(negedge clk);
  endtask

  // Enable step: takes effect at the next edge.
  task automatic en_step(logic n_en, logic ns, logic np, string tag);
    int unsigned c;
    @(negedge clk);
    en = n_en;
    c = cyc;
    push(c + 1, ns, np, 1'b0, tag);
    push(c + 3, ns, np, 1'b0, tag);
    cur_s = ns; cur_p = np;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; en = 1'b1; ie = 1'b1;
    cur_s = 1'b0; cur_p = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    push(cyc + 1, 1'b0, 1'b0, 1'b0, "R1 reset state");
    repeat (2) @(negedge clk);

    line_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R2 start");
    line_step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 scl low");
    line_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 sda rise scl low");
    line_step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 sda fall scl low");
    line_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 scl rise");
    line_step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R3 R6 stop with irq");
    line_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 start after stop");
    line_step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 scl low");
    line_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 sda up");
    line_step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 scl up");
    line_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 repeated start");
    ie = 1'b0;
    line_step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R7 masked stop");
    ie = 1'b1;
    line_step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4 scl low idle");
    line_step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 sda low idle");
    line_step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R4 scl up idle");
    line_step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R7 stop without start");
    line_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R2 start again");
    en_step(1'b0, 1'b0, 1'b0, "R5 disable clears");
    line_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 stop ignored");
    line_step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 start ignored");
    en_step(1'b1, 1'b0, 1'b0, "R5 reenable idle");
    line_step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R7 idle stop no irq");

    repeat (6) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R9: %0d expectations never compared, expected 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule